// File: doc/BRIEF.md
# Synchronized Interrupt Request Capture

This block is the front end of an interrupt controller. It takes a vector of request lines that may change at any time with respect to the controller clock. Each line first passes through a chain of registers that resynchronizes it. After that, the line is treated as edge-sensitive or level-sensitive according to a per-line static parameter bit.

An edge-sensitive line turns each rising transition of its resynchronized value into a one-clock set pulse. A level-sensitive line drives a set request for as long as its resynchronized value is high. The set requests load sticky pending bits. Software clears these bits by asserting an acknowledge strobe together with a write-one-to-clear mask.

A single registered interrupt output reports whether any pending bit is enabled by the per-line enable mask.

Top module: `irq_capture_top`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted at a clock edge, the synchronizer stages, all pending bits and `irq_o` become 0 at that edge.
- R2: Every request line passes through SYNC_STAGES registers (default 3) before any decision is made. An edge-sensitive line's pending bit becomes 1 at the third rising clock edge after the request rises. A level-sensitive line's pending bit becomes 1 at the fourth such edge.
- R3: An edge-sensitive line (EDGE_MASK bit i = 1) produces a single one-clock set pulse per rising transition, taken from the last two synchronizer stages. A request held high therefore sets its pending bit only once: if that bit is acknowledged while the request stays high, it stays 0.
- R4: A falling transition on an edge-sensitive line does not set its pending bit.
- R5: A pending bit stays 1 until a clock edge at which `ack_valid` = 1 and `ack_mask` bit i = 1; that edge clears it. Pending bits whose `ack_mask` bit is 0 are unchanged.
- R6: When a set request and an acknowledge hit the same pending bit at the same edge, the bit stays 1.
- R7: A level-sensitive line (EDGE_MASK bit i = 0) requests a set on every cycle in which its last synchronizer stage is 1. An acknowledge while the line is still high leaves the bit at 1. Once the line has been low for long enough, an acknowledge clears it.
- R8: `irq_o` is a register loaded each cycle with the OR over i of (pending bit i AND `enable_mask` bit i). It therefore follows a change of pending or enable one clock later.
- R9: The edge or level choice is made per line by the parameter EDGE_MASK. The default 8'h0F makes lines 0 to 3 edge-sensitive and lines 4 to 7 level-sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_async | input | NUM_SRC | Request lines, asynchronous to clk |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_mask | input | NUM_SRC | Write-one-to-clear mask used with ack_valid |
| enable_mask | input | NUM_SRC | Per-line enable for the interrupt output |
| pending_o | output | NUM_SRC | Sticky pending bits |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench measures the exact number of edges between a request change and the pending and interrupt outputs. A design that tapped the raw input, or one stage too few or too many, would show its pending bit one or more cycles early or late.

It places an acknowledge on exactly the edge where a fresh set pulse arrives. A design that lets the clear win would lose that interrupt.

It acknowledges an edge line that is still held high, and separately drops a cleared edge line low. A level-style or both-edge detector would then set the bit again. It also acknowledges a level line that is still high, which a design without set priority would wrongly clear.

Finally, it masks and unmasks pending lines to check that the interrupt output follows the enable mask one cycle later.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    function automatic sense_e sense_of(input logic cfg_bit);
        return cfg_bit ? SENSE_EDGE : SENSE_LEVEL;
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic tap_new,
    output logic tap_old
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign tap_new = chain_q[LAST-1];
    assign tap_old = chain_q[LAST];
endmodule

// File: rtl/irq_sense.sv
module irq_sense
    import irq_pkg::*;
#(
    parameter sense_e SENSE = SENSE_EDGE
) (
    input  logic tap_new,
    input  logic tap_old,
    output logic set_o
);
    logic rise;

    always_comb begin
        rise  = tap_new & ~tap_old;
        set_o = (SENSE == SENSE_EDGE) ? rise : tap_old;
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               ack_valid,
    input  logic [NUM_SRC-1:0] ack_mask,
    input  logic [NUM_SRC-1:0] enable_mask,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               irq;
    } state_t;

    state_t state_d, state_q;
    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        clr_vec       = ack_valid ? ack_mask : '0;
        state_d.pend  = (state_q.pend & ~clr_vec) | set_vec;
        state_d.irq   = |(state_q.pend & enable_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pending_o = state_q.pend;
    assign irq_o     = state_q.irq;
endmodule

// File: rtl/irq_capture_top.sv
module irq_capture_top
    import irq_pkg::*;
#(
    parameter int                 NUM_SRC     = 8,
    parameter int                 SYNC_STAGES = 3,
    parameter logic [NUM_SRC-1:0] EDGE_MASK   = 8'h0F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_async,
    input  logic               ack_valid,
    input  logic [NUM_SRC-1:0] ack_mask,
    input  logic [NUM_SRC-1:0] enable_mask,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] tap_new_vec;
    logic [NUM_SRC-1:0] tap_old_vec;
    logic [NUM_SRC-1:0] set_vec;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        irq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .din     (req_async[i]),
            .tap_new (tap_new_vec[i]),
            .tap_old (tap_old_vec[i])
        );
        irq_sense #(.SENSE(sense_of(EDGE_MASK[i]))) u_sense (
            .tap_new (tap_new_vec[i]),
            .tap_old (tap_old_vec[i]),
            .set_o   (set_vec[i])
        );
    end

    irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (set_vec),
        .ack_valid   (ack_valid),
        .ack_mask    (ack_mask),
        .enable_mask (enable_mask),
        .pending_o   (pending_o),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 8'h0F
) (
    input logic               clk,
    input logic               rst,
    input logic               ack_valid,
    input logic [NUM_SRC-1:0] ack_mask,
    input logic [NUM_SRC-1:0] enable_mask,
    input logic [NUM_SRC-1:0] set_vec,
    input logic [NUM_SRC-1:0] pending_o,
    input logic               irq_o
);
    // R1: reset clears pending and irq
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (pending_o == '0 && irq_o == 1'b0));

    // R3: an edge line never requests a set on two consecutive cycles
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & EDGE_MASK) != '0) |=> ((set_vec & $past(set_vec) & EDGE_MASK) == '0));

    // R5: acknowledged bits without a set request are 0 afterwards
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> ((pending_o & $past(ack_mask) & ~$past(set_vec)) == '0));

    // R6: a set request always lands, even against an acknowledge
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pending_o & $past(set_vec)) == $past(set_vec)));

    // R5: a pending bit only rises when a set was requested
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending_o & ~$past(pending_o) & ~$past(set_vec)) == '0));

    // R8: irq follows enabled pending one cycle later
    p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(pending_o & enable_mask))));
endmodule

bind irq_capture_top irq_capture_chk #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_valid   (ack_valid),
    .ack_mask    (ack_mask),
    .enable_mask (enable_mask),
    .set_vec     (set_vec),
    .pending_o   (pending_o),
    .irq_o       (irq_o)
);

// File: tb/sim_irq_capture_top.sv
module sim_irq_capture_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_async   = '0;
    logic         ack_valid   = 1'b0;
    logic [N-1:0] ack_mask    = '0;
    logic [N-1:0] enable_mask = '1;
    logic [N-1:0] pending_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_capture_top #(.NUM_SRC(N), .SYNC_STAGES(3), .EDGE_MASK(8'h0F)) u0 (
        .clk(clk), .rst(rst), .req_async(req_async), .ack_valid(ack_valid),
        .ack_mask(ack_mask), .enable_mask(enable_mask),
        .pending_o(pending_o), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_ack(input logic [N-1:0] m);
        ack_valid = 1'b1;
        ack_mask  = m;
        tick(1);
        ack_valid = 1'b0;
        ack_mask  = '0;
    endtask

    task automatic quiesce();
        req_async   = '0;
        enable_mask = '1;
        tick(5);
        do_ack('1);
        tick(1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        chk("R1 pending", {24'd0, pending_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_edge_latency();
        req_async[0] = 1'b1;
        tick(2);
        chk("R2 edge not yet", {24'd0, pending_o}, 32'h00);
        tick(1);
        chk("R2 edge pending", {24'd0, pending_o}, 32'h01);
        chk("R8 irq lags", {31'd0, irq_o}, 32'd0);
        tick(1);
        chk("R8 irq up", {31'd0, irq_o}, 32'd1);
        quiesce();
    endtask

    task automatic t_level_latency();
        req_async[4] = 1'b1;
        tick(3);
        chk("R2 level not yet", {24'd0, pending_o}, 32'h00);
        tick(1);
        chk("R2 level pending", {24'd0, pending_o}, 32'h10);
        do_ack(8'h10);
        chk("R7 ack while high", {24'd0, pending_o}, 32'h10);
        req_async[4] = 1'b0;
        tick(4);
        do_ack(8'h10);
        chk("R7 ack after release", {24'd0, pending_o}, 32'h00);
        quiesce();
    endtask

    task automatic t_edge_held();
        req_async[1] = 1'b1;
        tick(4);
        chk("R3 held set once", {24'd0, pending_o}, 32'h02);
        do_ack(8'h02);
        tick(4);
        chk("R3 no re-set while held", {24'd0, pending_o}, 32'h00);
        req_async[1] = 1'b0;
        tick(5);
        chk("R4 fall ignored", {24'd0, pending_o}, 32'h00);
        quiesce();
    endtask

    task automatic t_partial_ack();
        req_async[2] = 1'b1;
        req_async[3] = 1'b1;
        tick(4);
        chk("R5 two pending", {24'd0, pending_o}, 32'h0C);
        do_ack(8'h04);
        chk("R5 partial ack", {24'd0, pending_o}, 32'h08);
        tick(3);
        chk("R5 sticky", {24'd0, pending_o}, 32'h08);
        quiesce();
    endtask

    task automatic t_set_wins();
        req_async[0] = 1'b1;
        tick(4);
        req_async[0] = 1'b0;
        tick(4);
        chk("R6 pre pending", {24'd0, pending_o}, 32'h01);
        req_async[0] = 1'b1;
        tick(2);
        do_ack(8'h01);
        chk("R6 set beats ack", {24'd0, pending_o}, 32'h01);
        do_ack(8'h01);
        chk("R6 later ack clears", {24'd0, pending_o}, 32'h00);
        quiesce();
    endtask

    task automatic t_enable();
        enable_mask = 8'h00;
        req_async[5] = 1'b1;
        tick(6);
        chk("R9 level line pending", {24'd0, pending_o}, 32'h20);
        chk("R8 masked irq", {31'd0, irq_o}, 32'd0);
        enable_mask = 8'h20;
        tick(1);
        chk("R8 enabled irq", {31'd0, irq_o}, 32'd1);
        enable_mask = 8'h00;
        tick(1);
        chk("R8 disabled again", {31'd0, irq_o}, 32'd0);
        quiesce();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_edge_latency();
        t_level_latency();
        t_edge_held();
        t_partial_ack();
        t_set_wins();
        t_enable();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule